// File: doc/BRIEF.md
# Partial-flag offset unit for a dual-clock FIFO

This block stores the two thresholds that decide when a FIFO is nearly empty and when it is nearly full. It turns the occupancy counts it receives into the two partial flags. One count is kept in the write-clock domain and one in the read-clock domain. The FIFO storage and its pointers live elsewhere. This block only sees a word count per domain and the shared resets.

Thresholds can be loaded in two ways:

- **Parallel:** a whole word, or a byte piece, is taken from the data bus on each write clock while the load strobe and the write enable are low.
- **Serial:** one bit per write clock is taken from data bit 0 while the load strobe and the serial enable are low.

A separate pointer in the read domain walks the same pieces for read-back. Each flag carries a valid qualifier. The qualifier drops while programming is under way and comes back a fixed number of clock edges after the last needed piece is written.

Two configurations are available:

- **Wide (18-bit bus):** each threshold is a single word.
- **Narrow (9-bit bus):** each threshold is split into a low byte and an upper part.

Top module: `pflag_offset_unit`

## Requirements
- R1: On a write clock edge with master reset high, both thresholds load 0x3FF if the load strobe is high and 0x07F if it is low. Both valid qualifiers read 1, `ae` reads 1 and `af` reads 0.
- R2: Partial reset leaves both thresholds unchanged. It returns the load pointer, the serial bit position and the read-back pointer to their first position, and marks both flags valid.
- R3: Parallel loads walk the pieces in a fixed cycle and then wrap. In wide mode the cycle is empty threshold, then full threshold. In narrow mode it is empty low byte (data[7:0]), empty upper part (data[OFS_W-9:0] into bits OFS_W-1..8), full low byte, full upper part.
- R4: A serial load takes data bit 0 into bit position k of a 2*OFS_W-bit sequence on each write clock while `ld_n`=0, `sen_n`=0 and `wen_n`=1. Positions 0..OFS_W-1 are the empty threshold, LSB first, and the rest are the full threshold. With either strobe high, the position holds and loading later resumes from it.
- R5: The first parallel piece of a cycle (pointer at the empty piece) clears the full flag's valid source. A flag's valid source is cleared by a non-final piece of its own threshold and set by its final piece.
- R6: From the first serial bit until the last bit, both valid sources stay cleared.
- R7: `af_vld` follows its valid source two write-clock edges later. `ae_vld` follows its source two read-clock edges later, through a two-stage synchronizer.
- R8: On a read-clock edge with `ld_n`=0 and `ren_n`=0, `ofs_q` takes the piece at the read-back pointer and the pointer advances in the R3 order with wrap. The read-back pointer never moves the load pointer.
- R9: Threshold bits that the data bus does not supply read back as zero. In wide mode these are bits DATA_W-1..OFS_W. In narrow mode they are the bits of a piece above its width.
- R10: `ae` is registered on the read clock as `rd_level` <= empty threshold.
- R11: `af` is registered on the write clock as (DEPTH - `wr_level`) <= full threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst | input | 1 | Master reset, active high, synchronous in both domains |
| prst | input | 1 | Partial reset, active high, synchronous in both domains |
| ld_n | input | 1 | Threshold load strobe, active low; its level at master reset picks the default |
| wen_n | input | 1 | Write enable for parallel loads, active low |
| sen_n | input | 1 | Serial load enable, active low |
| ren_n | input | 1 | Read enable for read-back, active low |
| din | input | DATA_W | Data bus; bit 0 is the serial input |
| wr_level | input | CNT_W | Occupancy seen in the write domain |
| rd_level | input | CNT_W | Occupancy seen in the read domain |
| ofs_q | output | DATA_W | Read-back piece |
| ae | output | 1 | Almost-empty flag |
| ae_vld | output | 1 | Almost-empty valid qualifier |
| af | output | 1 | Almost-full flag |
| af_vld | output | 1 | Almost-full valid qualifier |

## Verification
The bench runs a wide and a narrow instance side by side on the same controls. This exposes a design that mixes up the piece order or the wrap point: the read-back words of one variant would then disagree with the bench model.

Serial loading is interrupted twice mid-stream, once by the serial enable alone and once by the load strobe. A design that kept shifting during a pause, or restarted at bit 0, would corrupt the threshold reported on read-back.

The valid qualifiers are sampled on exactly the first and second edges after the completing write. This catches a pipeline that is one stage short or one stage long.

Occupancy is driven at, one below and one above each threshold, and at 0 and DEPTH. This catches a strict comparison used in place of an inclusive one.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

   // Load / read-back piece order. Wide mode uses only E_LO (whole empty
   // threshold) and F_LO (whole full threshold).
   typedef enum logic [1:0] {
      STP_E_LO = 2'd0,
      STP_E_HI = 2'd1,
      STP_F_LO = 2'd2,
      STP_F_HI = 2'd3
   } step_e;

   function automatic step_e step_next(input step_e s, input logic narrow);
      if (narrow)
         return step_e'(s + 2'd1);
      else
         return (s == STP_E_LO) ? STP_F_LO : STP_E_LO;
   endfunction

   function automatic logic step_is_full(input step_e s);
      return s[1];
   endfunction

   // True when the piece is the last one of its threshold.
   function automatic logic step_closes(input step_e s, input logic narrow);
      return narrow ? s[0] : 1'b1;
   endfunction

endpackage

// File: rtl/pfo_offset_regs.sv
module pfo_offset_regs
   import pfo_pkg::*;
#(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18,
   parameter int NARROW = 0
)(
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              ld_n,
   input  logic              wen_n,
   input  logic              sen_n,
   input  logic [DATA_W-1:0] din,
   output logic [OFS_W-1:0]  e_ofs,
   output logic [OFS_W-1:0]  f_ofs,
   output logic              e_ok,
   output logic              f_ok
);

   localparam logic NAR   = (NARROW != 0);
   localparam int   NBITS = 2 * OFS_W;
   localparam int   SC_W  = $clog2(NBITS);
   localparam int   HI_W  = OFS_W - 8;
   localparam logic [OFS_W-1:0] DEF_SMALL = OFS_W'(12'h07F);
   localparam logic [OFS_W-1:0] DEF_LARGE = OFS_W'(12'h3FF);
   localparam step_e LAST_STEP = NAR ? STP_F_HI : STP_F_LO;

   step_e            lptr;
   logic [SC_W-1:0]  scnt;
   logic [OFS_W-1:0] cur_ofs;
   logic [OFS_W-1:0] pw_val;
   logic [OFS_W-1:0] e_mask;
   logic [OFS_W-1:0] f_mask;
   logic             pwr;
   logic             shf;
   logic             last_bit;
   logic             closes;
   logic             unused_din;

   assign unused_din = ^din;
   assign pwr        = !ld_n && !wen_n;
   assign shf        = !ld_n && wen_n && !sen_n;
   assign last_bit   = (scnt == SC_W'(NBITS - 1));
   assign closes     = step_closes(lptr, NAR);
   assign cur_ofs    = step_is_full(lptr) ? f_ofs : e_ofs;

   // Piece merge: variant picked by the bus width.
   generate
      if (NAR) begin : g_narrow
         always_comb begin
            if (lptr[0])
               pw_val = {din[HI_W-1:0], cur_ofs[7:0]};
            else
               pw_val = {cur_ofs[OFS_W-1:8], din[7:0]};
         end
      end else begin : g_wide
         always_comb pw_val = din[OFS_W-1:0];
      end
   endgenerate

   // Bit-select masks for the serial position.
   always_comb begin
      e_mask = '0;
      f_mask = '0;
      if (scnt < SC_W'(OFS_W))
         e_mask = OFS_W'(1) << scnt;
      else
         f_mask = OFS_W'(1) << (scnt - SC_W'(OFS_W));
   end

   always_ff @(posedge clk) begin
      if (mrst) begin
         e_ofs <= ld_n ? DEF_LARGE : DEF_SMALL;
         f_ofs <= ld_n ? DEF_LARGE : DEF_SMALL;
         lptr  <= STP_E_LO;
         scnt  <= '0;
         e_ok  <= 1'b1;
         f_ok  <= 1'b1;
      end else if (prst) begin
         lptr  <= STP_E_LO;
         scnt  <= '0;
         e_ok  <= 1'b1;
         f_ok  <= 1'b1;
      end else if (pwr) begin
         scnt <= '0;
         lptr <= step_next(lptr, NAR);
         if (step_is_full(lptr)) begin
            f_ofs <= pw_val;
            f_ok  <= closes;
         end else begin
            e_ofs <= pw_val;
            e_ok  <= closes;
            if (lptr == STP_E_LO)
               f_ok <= 1'b0;
         end
      end else if (shf) begin
         e_ofs <= din[0] ? (e_ofs | e_mask) : (e_ofs & ~e_mask);
         f_ofs <= din[0] ? (f_ofs | f_mask) : (f_ofs & ~f_mask);
         scnt  <= last_bit ? '0 : scnt + SC_W'(1);
         e_ok  <= last_bit;
         f_ok  <= last_bit;
      end
   end

   a_r3_load_wrap: assert property (@(posedge clk) disable iff (mrst || prst)
      (pwr && lptr == LAST_STEP) |=> (lptr == STP_E_LO));

   a_r4_pos_range: assert property (@(posedge clk) disable iff (mrst)
      scnt < SC_W'(NBITS));

   a_r6_serial_blocks: assert property (@(posedge clk) disable iff (mrst || prst)
      (scnt != '0) |-> (!e_ok && !f_ok));

   a_r2_prst_keeps: assert property (@(posedge clk) disable iff (mrst)
      prst |=> ($stable(e_ofs) && $stable(f_ofs)));

endmodule

// File: rtl/pfo_readback.sv
module pfo_readback
   import pfo_pkg::*;
#(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18,
   parameter int NARROW = 0
)(
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              ld_n,
   input  logic              ren_n,
   input  logic [OFS_W-1:0]  e_ofs,
   input  logic [OFS_W-1:0]  f_ofs,
   output logic [DATA_W-1:0] q
);

   localparam logic NAR = (NARROW != 0);

   step_e             rb_ptr;
   logic [DATA_W-1:0] word;
   logic              rd;

   assign rd = !ld_n && !ren_n;

   generate
      if (NAR) begin : g_narrow
         always_comb begin
            case (rb_ptr)
               STP_E_LO: word = DATA_W'(e_ofs[7:0]);
               STP_E_HI: word = DATA_W'(e_ofs[OFS_W-1:8]);
               STP_F_LO: word = DATA_W'(f_ofs[7:0]);
               default:  word = DATA_W'(f_ofs[OFS_W-1:8]);
            endcase
         end
      end else begin : g_wide
         always_comb word = step_is_full(rb_ptr) ? DATA_W'(f_ofs) : DATA_W'(e_ofs);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (mrst || prst) begin
         rb_ptr <= STP_E_LO;
         q      <= '0;
      end else if (rd) begin
         q      <= word;
         rb_ptr <= step_next(rb_ptr, NAR);
      end
   end

   a_r8_ptr_holds: assert property (@(posedge clk) disable iff (mrst || prst)
      !rd |=> $stable(rb_ptr));

   a_r8_ptr_moves: assert property (@(posedge clk) disable iff (mrst || prst)
      rd |=> (rb_ptr != $past(rb_ptr)));

endmodule

// File: rtl/pfo_vld_pipe.sv
module pfo_vld_pipe #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst,
   input  logic ok_i,
   output logic vld_o
);

   logic [STAGES-1:0] stg;
   logic [1:0]        age;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg <= '1;
         age <= '0;
      end else begin
         stg <= {stg[STAGES-2:0], ok_i};
         if (age != 2'd3)
            age <= age + 2'd1;
      end
   end

   assign vld_o = stg[STAGES-1];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfo_vld_pipe needs at least two stages");
      end
      if (STAGES == 2) begin : g_chk2
         a_r7_rise_delay: assert property (@(posedge clk) disable iff (rst)
            (age == 2'd3 && $rose(vld_o)) |-> $past(ok_i, 2));
         a_r7_fall_delay: assert property (@(posedge clk) disable iff (rst)
            (age == 2'd3 && $fell(vld_o)) |-> !$past(ok_i, 2));
      end
   endgenerate

endmodule

// File: rtl/pfo_flag_cmp.sv
module pfo_flag_cmp #(
   parameter int   CMP_W   = 14,
   parameter logic RST_VAL = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [CMP_W-1:0] level,
   input  logic [CMP_W-1:0] limit,
   output logic             flag_o
);

   always_ff @(posedge clk) begin
      if (rst)
         flag_o <= RST_VAL;
      else
         flag_o <= (level <= limit);
   end

endmodule

// File: rtl/pflag_offset_unit.sv
module pflag_offset_unit
   import pfo_pkg::*;
#(
   parameter  int DEPTH  = 8192,
   parameter  int OFS_W  = 13,
   parameter  int NARROW = 0,
   localparam int DATA_W = (NARROW != 0) ? 9 : 18,
   localparam int CNT_W  = $clog2(DEPTH + 1)
)(
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              ld_n,
   input  logic              wen_n,
   input  logic              sen_n,
   input  logic              ren_n,
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  wr_level,
   input  logic [CNT_W-1:0]  rd_level,
   output logic [DATA_W-1:0] ofs_q,
   output logic              ae,
   output logic              ae_vld,
   output logic              af,
   output logic              af_vld
);

   localparam int CMP_W = (CNT_W > OFS_W) ? CNT_W : OFS_W;

   generate
      if (OFS_W < 10 || OFS_W > ((NARROW != 0) ? 17 : 18)) begin : g_bad_ofs
         $error("OFS_W out of range for the selected bus width");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   logic [OFS_W-1:0] e_ofs;
   logic [OFS_W-1:0] f_ofs;
   logic             e_ok;
   logic             f_ok;
   logic             rst_any;
   logic [CMP_W-1:0] free_w;

   assign rst_any = mrst || prst;
   assign free_w  = CMP_W'(DEPTH) - CMP_W'(wr_level);

   pfo_offset_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NARROW(NARROW)) u_regs (
      .clk   (wclk),
      .mrst  (mrst),
      .prst  (prst),
      .ld_n  (ld_n),
      .wen_n (wen_n),
      .sen_n (sen_n),
      .din   (din),
      .e_ofs (e_ofs),
      .f_ofs (f_ofs),
      .e_ok  (e_ok),
      .f_ok  (f_ok)
   );

   // Thresholds are quasi-static while flags are in use; read side samples them directly.
   pfo_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NARROW(NARROW)) u_rb (
      .clk   (rclk),
      .mrst  (mrst),
      .prst  (prst),
      .ld_n  (ld_n),
      .ren_n (ren_n),
      .e_ofs (e_ofs),
      .f_ofs (f_ofs),
      .q     (ofs_q)
   );

   pfo_vld_pipe #(.STAGES(2)) u_af_vld (
      .clk   (wclk),
      .rst   (rst_any),
      .ok_i  (f_ok),
      .vld_o (af_vld)
   );

   pfo_vld_pipe #(.STAGES(2)) u_ae_vld (
      .clk   (rclk),
      .rst   (rst_any),
      .ok_i  (e_ok),
      .vld_o (ae_vld)
   );

   pfo_flag_cmp #(.CMP_W(CMP_W), .RST_VAL(1'b1)) u_ae (
      .clk    (rclk),
      .rst    (rst_any),
      .level  (CMP_W'(rd_level)),
      .limit  (CMP_W'(e_ofs)),
      .flag_o (ae)
   );

   pfo_flag_cmp #(.CMP_W(CMP_W), .RST_VAL(1'b0)) u_af (
      .clk    (wclk),
      .rst    (rst_any),
      .level  (free_w),
      .limit  (CMP_W'(f_ofs)),
      .flag_o (af)
   );

   a_r10_empty_sets_ae: assert property (@(posedge rclk) disable iff (rst_any)
      (rd_level == '0) |=> ae);

   a_r11_full_sets_af: assert property (@(posedge wclk) disable iff (rst_any)
      (wr_level == CNT_W'(DEPTH)) |=> af);

endmodule

// File: tb/pflag_offset_unit_tb.sv
module pflag_offset_unit_tb;

   logic        wclk = 1'b0;
   logic        rclk = 1'b0;
   logic        mrst = 1'b1;
   logic        prst = 1'b0;
   logic        ld_n = 1'b1;
   logic        wen_n = 1'b1;
   logic        sen_n = 1'b1;
   logic        ren_n = 1'b1;
   logic [17:0] din = '0;
   logic [13:0] wr_level = '0;
   logic [13:0] rd_level = '0;

   logic [17:0] w_q;
   logic        w_ae, w_aev, w_af, w_afv;
   logic [8:0]  n_q;
   logic        n_ae, n_aev, n_af, n_afv;

   int n_chk = 0;
   int n_fail = 0;

   // Bench model of both variants.
   logic [12:0] m_e, m_f, n_e, n_f;
   int w_rp, n_rp, s_cnt;
   logic [1:0] n_lp;
   logic       w_lp;

   always #5 wclk = ~wclk;
   initial begin
      #2;
      forever begin
         rclk = 1'b1; #7;
         rclk = 1'b0; #7;
      end
   end

   pflag_offset_unit #(.DEPTH(8192), .OFS_W(13), .NARROW(0)) u_dut (
      .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ld_n(ld_n),
      .wen_n(wen_n), .sen_n(sen_n), .ren_n(ren_n), .din(din),
      .wr_level(wr_level), .rd_level(rd_level), .ofs_q(w_q),
      .ae(w_ae), .ae_vld(w_aev), .af(w_af), .af_vld(w_afv)
   );

   pflag_offset_unit #(.DEPTH(8192), .OFS_W(13), .NARROW(1)) u_nar (
      .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ld_n(ld_n),
      .wen_n(wen_n), .sen_n(sen_n), .ren_n(ren_n), .din(din[8:0]),
      .wr_level(wr_level), .rd_level(rd_level), .ofs_q(n_q),
      .ae(n_ae), .ae_vld(n_aev), .af(n_af), .af_vld(n_afv)
   );

   function automatic logic [17:0] w_word(input int p, input logic [12:0] e, input logic [12:0] f);
      return (p != 0) ? 18'(f) : 18'(e);
   endfunction

   function automatic logic [8:0] n_word(input int p, input logic [12:0] e, input logic [12:0] f);
      case (p)
         0:       return 9'(e[7:0]);
         1:       return 9'(e[12:8]);
         2:       return 9'(f[7:0]);
         default: return 9'(f[12:8]);
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic w_edge;
      @(posedge wclk); #2;
   endtask

   task automatic r_edge;
      @(posedge rclk); #2;
   endtask

   task automatic do_mreset(input logic ldv);
      w_edge;
      mrst = 1'b1;
      ld_n = ldv;
      repeat (4) w_edge;
      repeat (3) r_edge;
      w_edge;
      mrst = 1'b0;
      ld_n = 1'b1;
      m_e = ldv ? 13'h3FF : 13'h07F;
      m_f = m_e; n_e = m_e; n_f = m_e;
      w_lp = 1'b0; n_lp = 2'd0; w_rp = 0; n_rp = 0; s_cnt = 0;
   endtask

   task automatic do_prst;
      w_edge;
      prst = 1'b1;
      repeat (3) w_edge;
      repeat (2) r_edge;
      w_edge;
      prst = 1'b0;
      w_lp = 1'b0; n_lp = 2'd0; w_rp = 0; n_rp = 0; s_cnt = 0;
   endtask

   task automatic pwrite(input logic [17:0] d);
      w_edge;
      ld_n = 1'b0; wen_n = 1'b0; din = d;
      w_edge;
      ld_n = 1'b1; wen_n = 1'b1;
      if (w_lp) m_f = d[12:0]; else m_e = d[12:0];
      w_lp = ~w_lp;
      case (n_lp)
         2'd0: n_e[7:0]  = d[7:0];
         2'd1: n_e[12:8] = d[4:0];
         2'd2: n_f[7:0]  = d[7:0];
         default: n_f[12:8] = d[4:0];
      endcase
      n_lp = n_lp + 2'd1;
      s_cnt = 0;
   endtask

   task automatic sbit(input logic b);
      ld_n = 1'b0; sen_n = 1'b0; wen_n = 1'b1; din = {17'h0, b};
      w_edge;
      if (s_cnt < 13) begin
         m_e[s_cnt] = b; n_e[s_cnt] = b;
      end else begin
         m_f[s_cnt-13] = b; n_f[s_cnt-13] = b;
      end
      s_cnt = (s_cnt + 1) % 26;
   endtask

   task automatic readback(input int cnt, input string req);
      r_edge;
      ld_n = 1'b0; ren_n = 1'b0;
      for (int i = 0; i < cnt; i++) begin
         r_edge;
         chk({req, " wide read-back"}, 32'(w_q), 32'(w_word(w_rp, m_e, m_f)));
         chk({req, " narrow read-back"}, 32'(n_q), 32'(n_word(n_rp, n_e, n_f)));
         w_rp = (w_rp + 1) % 2;
         n_rp = (n_rp + 1) % 4;
      end
      ld_n = 1'b1; ren_n = 1'b1;
   endtask

   initial begin
      #1_500_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));

      // R1: defaults with the load strobe high at master reset
      do_mreset(1'b1);
      r_edge;
      chk("R1 reset ae", 32'(w_ae), 32'(1));
      chk("R1 reset af", 32'(w_af), 32'(0));
      chk("R1 reset ae_vld", 32'(w_aev), 32'(1));
      chk("R1 reset af_vld", 32'(w_afv), 32'(1));
      chk("R1 reset narrow vld", 32'({n_aev, n_afv}), 32'(3));
      readback(4, "R1 R8 default 3FF");

      // R1, R9: low defaults; narrow upper parts zero
      do_mreset(1'b0);
      readback(4, "R1 R9 default 07F");

      // R5, R3: parallel loads
      pwrite(18'h3E123);
      w_edge; w_edge;
      chk("R5 wide af_vld after empty word", 32'(w_afv), 32'(0));
      r_edge; r_edge; r_edge;
      chk("R5 wide ae_vld kept", 32'(w_aev), 32'(1));
      chk("R5 narrow ae_vld after low byte", 32'(n_aev), 32'(0));
      chk("R5 narrow af_vld after low byte", 32'(n_afv), 32'(0));

      pwrite(18'h1F456);
      chk("R7 wide af_vld at E0", 32'(w_afv), 32'(0));
      w_edge;
      chk("R7 wide af_vld after one edge", 32'(w_afv), 32'(0));
      w_edge;
      chk("R7 wide af_vld after two edges", 32'(w_afv), 32'(1));
      r_edge; r_edge; r_edge;
      chk("R5 narrow ae_vld after upper part", 32'(n_aev), 32'(1));
      chk("R5 narrow af_vld still pending", 32'(n_afv), 32'(0));

      pwrite(18'($urandom));
      pwrite(18'($urandom));
      repeat (3) w_edge;
      repeat (3) r_edge;
      chk("R5 narrow af_vld after full set", 32'(n_afv), 32'(1));
      chk("R5 wide af_vld after wrap", 32'(w_afv), 32'(1));
      readback(4, "R3 R9 parallel");

      // R4, R6: serial load with two kinds of pause
      for (int i = 0; i < 26; i++) begin
         sbit(1'($urandom));
         if (i == 9) begin
            ld_n = 1'b1; sen_n = 1'b1;
            repeat (4) w_edge;
            r_edge; r_edge; r_edge;
            chk("R6 wide vld during serial", 32'({w_aev, w_afv}), 32'(0));
            chk("R6 narrow vld during serial", 32'({n_aev, n_afv}), 32'(0));
         end
         if (i == 17) begin
            ld_n = 1'b0; sen_n = 1'b1;
            repeat (3) w_edge;
            ld_n = 1'b1; sen_n = 1'b0;
            repeat (2) w_edge;
         end
      end
      ld_n = 1'b1; sen_n = 1'b1;
      fork
         begin
            chk("R7 af_vld at serial end", 32'({w_afv, n_afv}), 32'(0));
            w_edge;
            chk("R7 af_vld one edge after", 32'({w_afv, n_afv}), 32'(0));
            w_edge;
            chk("R7 af_vld two edges after", 32'({w_afv, n_afv}), 32'(3));
         end
         begin
            r_edge;
            chk("R7 ae_vld one rclk after", 32'({w_aev, n_aev}), 32'(0));
            r_edge;
            chk("R7 ae_vld two rclk after", 32'({w_aev, n_aev}), 32'(3));
         end
      join
      readback(4, "R4 serial");

      // R2: partial reset keeps thresholds, resets pointers
      pwrite(18'($urandom));
      readback(1, "R8 before partial reset");
      do_prst;
      chk("R2 vld after partial reset", 32'({w_aev, w_afv, n_aev, n_afv}), 32'(15));
      readback(4, "R2 kept thresholds");
      pwrite(18'h00A5A);
      readback(4, "R2 load pointer restarted");
      pwrite(18'h01C3C);
      pwrite(18'h00077);
      pwrite(18'h00001);
      repeat (3) w_edge;
      readback(4, "R3 narrow full cycle");

      // R10: almost-empty compare
      for (int i = 0; i < 150; i++) begin
         int sel;
         int lv;
         sel = int'($urandom_range(0, 6));
         case (sel)
            0: lv = int'(m_e);
            1: lv = int'(m_e) + 1;
            2: lv = (m_e == 0) ? 0 : int'(m_e) - 1;
            3: lv = int'(n_e);
            4: lv = int'(n_e) + 1;
            5: lv = 0;
            default: lv = int'($urandom_range(0, 8192));
         endcase
         r_edge;
         rd_level = 14'(lv);
         r_edge;
         chk("R10 wide ae", 32'(w_ae), 32'(lv <= int'(m_e)));
         chk("R10 narrow ae", 32'(n_ae), 32'(lv <= int'(n_e)));
      end

      // R11: almost-full compare
      for (int i = 0; i < 150; i++) begin
         int sel;
         int lv;
         sel = int'($urandom_range(0, 6));
         case (sel)
            0: lv = 8192 - int'(m_f);
            1: lv = 8192 - int'(m_f) + 1;
            2: lv = 8192 - int'(m_f) - 1;
            3: lv = 8192 - int'(n_f);
            4: lv = 8192;
            5: lv = 0;
            default: lv = int'($urandom_range(0, 8192));
         endcase
         if (lv < 0) lv = 0;
         if (lv > 8192) lv = 8192;
         w_edge;
         wr_level = 14'(lv);
         w_edge;
         chk("R11 wide af", 32'(w_af), 32'((8192 - lv) <= int'(m_f)));
         chk("R11 narrow af", 32'(n_af), 32'((8192 - lv) <= int'(n_f)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule